// File: doc/BRIEF.md
# Multi-Precision Sliced ALU with Condition Status

This block is a 16-bit two's complement arithmetic and logic unit. It handles words longer than its datapath by taking them in 16-bit slices on consecutive cycles, least significant slice first. A strobe marks the first slice of an operation and a marker flags its last slice. A single-word operation sets both on the same cycle. Double-length operands take two slices and extended-length operands take three. Between slices the block keeps the carry or borrow and a running "all slices zero" term.

Each accepted slice gives a registered 16-bit result one cycle later, together with a result-valid flag. Compare is the exception: it writes no result. When the last slice is accepted, four status bits are loaded: carry, positive, zero and negative. Zero covers the whole multi-slice result. Positive and negative come from the top slice. Memory address formation is a single-slice add of a base and an offset, so it uses the ordinary add path.

Top module: `slice_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `res_valid`=0, `res`=0 and all four status bits at 0. The carry chain and the zero accumulator are cleared as well.
- R2: Arithmetic results follow the opcode encoding below and are modulo 2^16 per slice:
  - ADD (0) gives a+b+cin.
  - SUB (1) gives a+~b+cin.
  - NEG (6) gives ~a+cin.
  - PASS (7) gives a. Codes 9 to 15 also behave as PASS.
  - Address formation is ADD with first and last both set.
- R3: The logic opcodes are AND (2), OR (3), XOR (4) and NOT (5), where NOT gives ~a. Each is bitwise, uses no inter-slice carry, and leaves the carry flag at 0 when it ends an operation.
- R4: On a slice with `first`=1, the carry-in is 0 for ADD and 1 for SUB, CMP and NEG. On later slices the carry-in is the carry-out of the previous accepted slice. A new `first` discards any pending chain.
- R5: `flag_z` is 1 only when every slice of the operation, from its first slice to its last, has a zero result.
- R6: When the result is not zero, `flag_n` is bit 15 of the final slice and `flag_p` is its inverse. After any operation ends, exactly one of `flag_p`, `flag_z` and `flag_n` is 1.
- R7: The status bits change only on the cycle after a valid slice with `last`=1. Non-last slices and idle cycles leave them unchanged.
- R8: Compare (8) sets the status bits exactly as SUB would. It leaves `res_valid` at 0 and `res` unchanged.
- R9: `flag_c` is the carry-out of the final slice. For SUB, CMP and NEG it is 1 when there is no borrow.
- R10: Every accepted slice of a result-writing opcode shows its result on `res`, with `res_valid`=1, in the cycle after it is accepted. `res_valid` is 0 after any cycle with `in_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Slice present this cycle |
| op | input | 4 | Opcode |
| first | input | 1 | First (least significant) slice of an operation |
| last | input | 1 | Final (most significant) slice of an operation |
| a | input | 16 | Operand A slice |
| b | input | 16 | Operand B slice |
| res | output | 16 | Registered result slice |
| res_valid | output | 1 | `res` was written in the previous cycle |
| flag_c | output | 1 | Carry status |
| flag_p | output | 1 | Positive status |
| flag_z | output | 1 | Zero status |
| flag_n | output | 1 | Negative status |

## Verification
The assertions check these behaviours on every cycle:
- At most one of positive, zero and negative is set, and exactly one is set after an operation ends.
- The status bits stay stable unless a last slice was accepted.
- Compare never raises `res_valid`.
- Logic opcodes leave carry clear.
- The reset values are correct.

Only the bench scenarios can show the actual arithmetic values. They also show carry and borrow moving across two- and three-slice operations, a zero accumulator that sees a nonzero low slice under a zero top slice, and a fresh first strobe discarding a half-finished chain.

// File: rtl/slice_alu_pkg.sv
// Package: shared opcode type for the sliced ALU.
// Assumes a 4-bit opcode field; unlisted codes are handled as pass-A.
package slice_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOT  = 4'd5,
        OP_NEG  = 4'd6,
        OP_PASS = 4'd7,
        OP_CMP  = 4'd8
    } alu_op_e;
endpackage

// File: rtl/slice_alu_unit.sv
// Combinational slice operator: forms one result slice and its carry-out.
// Assumes carry_q holds the previous slice's carry-out; first overrides it.
module slice_alu_unit
    import slice_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic           first,
    input  logic           carry_q,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           cout,
    output logic           writes
);
    logic [W-1:0] a_sel;
    logic [W-1:0] b_sel;
    logic [W-1:0] logic_res;
    logic [W:0]   sum;
    logic         cin;
    logic         use_adder;

    // Select adder operands, carry-in and logic result for the opcode.
    always_comb begin
        a_sel     = a;
        b_sel     = b;
        cin       = 1'b0;
        use_adder = 1'b1;
        logic_res = a;
        case (op)
            OP_ADD: cin = first ? 1'b0 : carry_q;
            OP_SUB, OP_CMP: begin
                b_sel = ~b;
                cin   = first ? 1'b1 : carry_q;
            end
            OP_NEG: begin
                a_sel = ~a;
                b_sel = '0;
                cin   = first ? 1'b1 : carry_q;
            end
            OP_AND: begin use_adder = 1'b0; logic_res = a & b; end
            OP_OR:  begin use_adder = 1'b0; logic_res = a | b; end
            OP_XOR: begin use_adder = 1'b0; logic_res = a ^ b; end
            OP_NOT: begin use_adder = 1'b0; logic_res = ~a;    end
            default: begin use_adder = 1'b0; logic_res = a;    end
        endcase
    end

    // Shared adder and output mux.
    always_comb begin
        sum    = {1'b0, a_sel} + {1'b0, b_sel} + {{W{1'b0}}, cin};
        y      = use_adder ? sum[W-1:0] : logic_res;
        cout   = use_adder & sum[W];
        writes = (op != OP_CMP);
    end
endmodule

// File: rtl/slice_alu_chain.sv
// Inter-slice state: carry and running all-zero term between slices.
// Assumes slices of one operation arrive least significant first.
module slice_alu_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         first,
    input  logic         cout,
    input  logic [W-1:0] y,
    output logic         carry_q,
    output logic         zero_run
);
    logic zacc_q;

    // Zero term including the current slice; first restarts it.
    always_comb zero_run = (first | zacc_q) & (y == '0);

    // Hold carry and zero term for the next slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            zacc_q  <= 1'b0;
        end else if (step) begin
            carry_q <= cout;
            zacc_q  <= zero_run;
        end
    end
endmodule

// File: rtl/slice_alu_status.sv
// Condition status register: loads C, P, Z, N on the last slice only.
// Assumes sign is bit W-1 of the final slice result.
module slice_alu_status (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cout,
    input  logic zero_all,
    input  logic sign,
    output logic flag_c,
    output logic flag_p,
    output logic flag_z,
    output logic flag_n
);
    // Update status bits at the end of an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_c <= 1'b0;
            flag_p <= 1'b0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
        end else if (load) begin
            flag_c <= cout;
            flag_z <= zero_all;
            flag_n <= ~zero_all & sign;
            flag_p <= ~zero_all & ~sign;
        end
    end
endmodule

// File: rtl/slice_alu.sv
// Top: sliced two's complement ALU with registered result and status.
// Assumes multi-slice operations arrive on consecutive valid cycles.
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op,
    input  logic         first,
    input  logic         last,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         res_valid,
    output logic         flag_c,
    output logic         flag_p,
    output logic         flag_z,
    output logic         flag_n
);
    localparam int SIGN = W - 1;

    alu_op_e      op_e;
    logic [W-1:0] y;
    logic         cout;
    logic         writes;
    logic         carry_q;
    logic         zero_run;

    // Map the raw opcode field onto the enum.
    always_comb op_e = alu_op_e'(op);

    slice_alu_unit #(.W(W)) u_unit (
        .op(op_e), .first(first), .carry_q(carry_q),
        .a(a), .b(b), .y(y), .cout(cout), .writes(writes)
    );

    slice_alu_chain #(.W(W)) u_chain (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .first(first),
        .cout(cout), .y(y), .carry_q(carry_q), .zero_run(zero_run)
    );

    slice_alu_status u_status (
        .clk(clk), .rst_n(rst_n), .load(in_valid & last),
        .cout(cout), .zero_all(zero_run), .sign(y[SIGN]),
        .flag_c(flag_c), .flag_p(flag_p), .flag_z(flag_z), .flag_n(flag_n)
    );

    // Register the result slice for writing opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid & writes;
            if (in_valid & writes) res <= y;
        end
    end
endmodule

// File: rtl/slice_alu_chk.sv
// Checker: cycle-by-cycle properties of the sliced ALU, bound to the top.
// Assumes the top's port names.
module slice_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] op,
    input logic       last,
    input logic       res_valid,
    input logic       flag_c,
    input logic       flag_p,
    input logic       flag_z,
    input logic       flag_n
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !flag_c && !flag_p && !flag_z && !flag_n));

    // R6
    pzn_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_p, flag_z, flag_n}));

    // R6
    pzn_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last) |=> ($countones({flag_p, flag_z, flag_n}) == 1));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && last) |=> ($stable(flag_c) && $stable(flag_p)
                                 && $stable(flag_z) && $stable(flag_n)));

    // R8
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd8) |=> !res_valid);

    // R3
    logic_carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && last && op >= 4'd2 && op <= 4'd5) |=> !flag_c);

    // R10
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
endmodule

bind slice_alu slice_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .last(last),
    .res_valid(res_valid), .flag_c(flag_c), .flag_p(flag_p),
    .flag_z(flag_z), .flag_n(flag_n)
);

// File: tb/slice_alu_tb.sv
module slice_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] y;
        logic [3:0]  cpzn;
    } vec_t;

    // Single-slice vectors: op, a, b, expected result, expected {C,P,Z,N}
    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 16'h1234, 16'h0001, 16'h1235, 4'b0100},
        '{4'd0, 16'hFFFF, 16'h0001, 16'h0000, 4'b1010},
        '{4'd0, 16'h7FFF, 16'h0001, 16'h8000, 4'b0001},
        '{4'd1, 16'h0005, 16'h0003, 16'h0002, 4'b1100},
        '{4'd1, 16'h0003, 16'h0005, 16'hFFFE, 4'b0001},
        '{4'd1, 16'h1111, 16'h1111, 16'h0000, 4'b1010},
        '{4'd2, 16'hF0F0, 16'hFF00, 16'hF000, 4'b0001},
        '{4'd3, 16'h0F00, 16'h00F0, 16'h0FF0, 4'b0100},
        '{4'd4, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0010},
        '{4'd5, 16'h00FF, 16'h1234, 16'hFF00, 4'b0001},
        '{4'd6, 16'h0001, 16'h0000, 16'hFFFF, 4'b0001},
        '{4'd6, 16'h0000, 16'h0000, 16'h0000, 4'b1010},
        '{4'd7, 16'h4000, 16'h9999, 16'h4000, 4'b0100},
        '{4'd0, 16'h8000, 16'h0010, 16'h8010, 4'b0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        first = 1'b0;
    logic        last = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [15:0] res;
    logic        res_valid;
    logic        flag_c, flag_p, flag_z, flag_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .first(first), .last(last), .a(a), .b(b), .res(res),
        .res_valid(res_valid), .flag_c(flag_c), .flag_p(flag_p),
        .flag_z(flag_z), .flag_n(flag_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one slice at a falling edge; return just after the capturing edge.
    task automatic slice(input logic [3:0] o, input logic [15:0] x, input logic [15:0] z,
                         input logic f, input logic l);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = z; first = f; last = l;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; first = 1'b0; last = 1'b0;
    endtask

    function automatic logic [3:0] flags();
        return {flag_c, flag_p, flag_z, flag_n};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1 res", {16'd0, res}, 32'd0);
        chk("R1 flags", {28'd0, flags()}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R2 R3 R6 R9 table walk, single slice
        for (int i = 0; i < NVEC; i++) begin
            slice(VEC[i].op, VEC[i].a, VEC[i].b, 1'b1, 1'b1);
            chk($sformatf("R2 vec%0d res", i), {16'd0, res}, {16'd0, VEC[i].y});
            chk($sformatf("R10 vec%0d valid", i), {31'd0, res_valid}, 32'd1);
            chk($sformatf("R6 R9 vec%0d flags", i), {28'd0, flags()}, {28'd0, VEC[i].cpzn});
        end

        // R8 compare: flags like SUB, no write
        slice(4'd8, 16'h0003, 16'h0005, 1'b1, 1'b1);
        chk("R8 cmp valid", {31'd0, res_valid}, 32'd0);
        chk("R8 cmp res held", {16'd0, res}, 32'h8010);
        chk("R8 cmp flags", {28'd0, flags()}, 32'b0001);
        slice(4'd8, 16'h0007, 16'h0007, 1'b1, 1'b1);
        chk("R8 cmp equal flags", {28'd0, flags()}, 32'b1010);

        // R4 R7 32-bit add with carry into top slice
        slice(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b0);
        chk("R4 add lo", {16'd0, res}, 32'h0000);
        chk("R7 flags held mid-op", {28'd0, flags()}, 32'b1010);
        slice(4'd0, 16'h0001, 16'h0000, 1'b0, 1'b1);
        chk("R4 add hi", {16'd0, res}, 32'h0002);
        chk("R5 R9 add32 flags", {28'd0, flags()}, 32'b0100);

        // R4 48-bit subtract with borrow chain
        slice(4'd1, 16'h0000, 16'h0001, 1'b1, 1'b0);
        chk("R4 sub s0", {16'd0, res}, 32'hFFFF);
        slice(4'd1, 16'h0000, 16'h0000, 1'b0, 1'b0);
        chk("R4 sub s1", {16'd0, res}, 32'hFFFF);
        slice(4'd1, 16'h0000, 16'h0000, 1'b0, 1'b1);
        chk("R4 sub s2", {16'd0, res}, 32'hFFFF);
        chk("R6 R9 sub48 flags", {28'd0, flags()}, 32'b0001);

        // R5 48-bit all-zero result with carry out
        slice(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b0);
        slice(4'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        slice(4'd0, 16'hFFFF, 16'h0000, 1'b0, 1'b1);
        chk("R5 add48 top", {16'd0, res}, 32'h0000);
        chk("R5 add48 flags", {28'd0, flags()}, 32'b1010);

        // R5 nonzero low slice, zero top slice
        slice(4'd0, 16'h0005, 16'h0000, 1'b1, 1'b0);
        slice(4'd0, 16'h0000, 16'h0000, 1'b0, 1'b1);
        chk("R5 partial zero flags", {28'd0, flags()}, 32'b0100);

        // R4 first strobe discards a pending carry
        slice(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b0);
        slice(4'd0, 16'h0000, 16'h0000, 1'b1, 1'b1);
        chk("R4 restart res", {16'd0, res}, 32'h0000);
        chk("R4 restart flags", {28'd0, flags()}, 32'b0010);

        // R3 logic op ending a chain started by add: no carry used
        slice(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b0);
        slice(4'd3, 16'h0000, 16'h0000, 1'b0, 1'b1);
        chk("R3 or no carry res", {16'd0, res}, 32'h0000);
        chk("R3 or flags", {28'd0, flags()}, 32'b0010);

        // R7 R10 idle cycles hold flags and drop valid
        idle();
        @(posedge clk); #1;
        chk("R10 idle valid", {31'd0, res_valid}, 32'd0);
        chk("R7 idle flags", {28'd0, flags()}, 32'b0010);

        // R1 reset mid-operation clears everything
        slice(4'd0, 16'hFFFF, 16'h0001, 1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid reset valid", {31'd0, res_valid}, 32'd0);
        chk("R1 mid reset res", {16'd0, res}, 32'd0);
        chk("R1 mid reset flags", {28'd0, flags()}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        // after reset, chain carry cleared: continuation slice sees carry 0
        slice(4'd0, 16'h0001, 16'h0000, 1'b0, 1'b1);
        chk("R1 carry cleared", {16'd0, res}, 32'h0001);
        idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule